// File: doc/BRIEF.md
# Memory Domain Check and Data Fault Status

This block sits next to a memory management unit. It holds a 32-bit domain access control word with a 2-bit access code for each of 16 domains. Every access presented to it is checked against the code of the domain it targets. The result combines with the page-permission verdict supplied by the translation logic to raise either a domain fault or a permission fault, in the same cycle as the access.

The block also keeps a fault status register. The register records the domain number and a 4-bit fault type for the most recent data-side abort. Instruction-fetch aborts never touch it. Within a multi-word burst (load-multiple or store-multiple), only the first faulting beat is recorded.

Software reads and writes both registers through a simple port: a write strobe, a register select, 32-bit write data and a combinational read value.

Top module: `domain_fault_unit`

## Requirements
- R1: While reset is held and after it is released, both registers read as zero. After reset every domain therefore has code 00, and any valid access raises a domain fault.
- R2: A valid access to a domain whose code is 00 asserts the domain fault and not the permission fault, whatever the page-permission input is.
- R3: Code 10 behaves exactly like code 00: domain fault, no permission fault.
- R4: With code 01, the permission fault equals the inverse of the page-permission input and the domain fault stays low.
- R5: With code 11, neither fault is raised, whatever the page-permission input is.
- R6: Domain n uses bits [2n+1:2n] of the control word. A write with the select at 0 loads all 32 bits. The new codes govern accesses from the next cycle on, and the word reads back unchanged.
- R7: A valid data access that faults loads the status register at the next clock edge. Bits 7:4 take the access's domain number. Bits 3:0 take the fault type: 1001 for a domain fault on a section, 1011 for a domain fault on a page, 1101 for a permission fault on a section, and 1111 for a permission fault on a page.
- R8: A faulting instruction access (data flag low) leaves the status register unchanged.
- R9: The burst input is high for every beat of a burst. Once a fault has been recorded inside a burst, later faults in that burst are not recorded. Recording is possible again after the burst input has been low for at least one cycle.
- R10: A write with the select at 1 loads bits 7:0 of the write data into the status register. Bits 31:8 of the status read value are always zero.
- R11: When a fault is recorded in the same cycle as a software write to the status register, the recorded fault wins.
- R12: With the access-valid input low, neither fault output is asserted and the status register is not loaded by the access inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_domain_i | input | 4 | Domain number of the access |
| acc_is_data_i | input | 1 | 1 for a data access, 0 for an instruction fetch |
| acc_is_section_i | input | 1 | 1 for a section mapping, 0 for a page mapping |
| perm_ok_i | input | 1 | Page permission check passed |
| burst_i | input | 1 | Access is a beat of a multi-word burst |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the domain control word, 1 selects fault status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read value of the selected register |
| dom_fault_o | output | 1 | Domain fault for the current access |
| perm_fault_o | output | 1 | Permission fault for the current access |

## Verification
If a control-word field is stored at the wrong position or decoded wrongly, the fault outputs are wrong in the very cycle that domain is accessed. The register read value shows the same error in the cycle after the write.

A status register that records the wrong source shows up on the read port one cycle after the faulting access. This covers a wrong type code, a wrong domain, an instruction abort captured by mistake, or a later burst beat overwriting the first. A burst latch that fails to clear only shows up when a fault is presented on the first beat of the next burst, so the stimulus places faults exactly there.

// File: rtl/dchk_pkg.sv
`timescale 1ns/1ps
package dchk_pkg;

    typedef enum logic [1:0] {
        DOM_NONE   = 2'b00,
        DOM_CLIENT = 2'b01,
        DOM_RSVD   = 2'b10,
        DOM_MGR    = 2'b11
    } dom_code_e;

    localparam logic [3:0] FT_DOM_SECT  = 4'b1001;
    localparam logic [3:0] FT_DOM_PAGE  = 4'b1011;
    localparam logic [3:0] FT_PERM_SECT = 4'b1101;
    localparam logic [3:0] FT_PERM_PAGE = 4'b1111;

    localparam int FT_W = 4;

endpackage

// File: rtl/dchk_domain_ctl.sv
`timescale 1ns/1ps
module dchk_domain_ctl
    import dchk_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int DACR_W = 2 * NUM_DOM
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DACR_W-1:0] wdata_i,
    input  logic              acc_valid_i,
    input  logic [DOM_W-1:0]  acc_dom_i,
    input  logic              perm_ok_i,
    output logic              dom_fault_o,
    output logic              perm_fault_o,
    output logic [DACR_W-1:0] dacr_o
);

    typedef struct packed {
        logic [DACR_W-1:0] dacr;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    dom_code_e  codes [NUM_DOM];
    dom_code_e  sel_code;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
        assign codes[g] = dom_code_e'(st_q.dacr[2*g +: 2]);
    end

    assign sel_code = codes[acc_dom_i];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.dacr = wdata_i;
        end
    end

    always_comb begin
        dom_fault_o  = 1'b0;
        perm_fault_o = 1'b0;
        if (acc_valid_i) begin
            unique case (sel_code)
                DOM_NONE, DOM_RSVD: dom_fault_o  = 1'b1;
                DOM_CLIENT:         perm_fault_o = !perm_ok_i;
                DOM_MGR:            ;
                default:            dom_fault_o  = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dacr_o = st_q.dacr;

    // R2, R3, R4, R5: at most one kind of fault per access
    assert_fault_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dom_fault_o && perm_fault_o));

    // R12: an idle cycle raises nothing
    assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acc_valid_i |-> (!dom_fault_o && !perm_fault_o));

endmodule

// File: rtl/dchk_fault_status.sv
`timescale 1ns/1ps
module dchk_fault_status
    import dchk_pkg::*;
#(
    parameter int NUM_DOM = 16,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int STAT_W = DOM_W + FT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_valid_i,
    input  logic [DOM_W-1:0]  acc_dom_i,
    input  logic              is_data_i,
    input  logic              is_section_i,
    input  logic              burst_i,
    input  logic              dom_fault_i,
    input  logic              perm_fault_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] status_o
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              lock;
    } fs_state_t;

    fs_state_t       st_d, st_q;
    logic            record;
    logic [FT_W-1:0] ftype;

    always_comb begin
        if (dom_fault_i) begin
            ftype = is_section_i ? FT_DOM_SECT : FT_DOM_PAGE;
        end else begin
            ftype = is_section_i ? FT_PERM_SECT : FT_PERM_PAGE;
        end
    end

    always_comb begin
        record = acc_valid_i && is_data_i && (dom_fault_i || perm_fault_i)
                 && !(st_q.lock && burst_i);
        st_d = st_q;
        if (record) begin
            st_d.status = {acc_dom_i, ftype};
        end else if (wr_en_i) begin
            st_d.status = wdata_i;
        end
        st_d.lock = burst_i && (st_q.lock || record);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;

    // R7: a recorded fault stores the access domain
    assert_capture_domain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        record |=> status_o[STAT_W-1:FT_W] == $past(acc_dom_i));

    // R8: instruction side never alters the register
    assert_instr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!is_data_i && !wr_en_i) |=> $stable(status_o));

    // R9: a locked burst keeps its first fault
    assert_burst_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.lock && burst_i && !wr_en_i) |=> $stable(status_o));

    // R9: the lock drops once the burst ends
    assert_lock_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !burst_i |=> !st_q.lock);

endmodule

// File: rtl/domain_fault_unit.sv
`timescale 1ns/1ps
module domain_fault_unit
    import dchk_pkg::*;
#(
    parameter int NUM_DOM = 16,
    parameter int REG_W   = 32,
    localparam int DOM_W  = $clog2(NUM_DOM),
    localparam int DACR_W = 2 * NUM_DOM,
    localparam int STAT_W = DOM_W + FT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             acc_valid_i,
    input  logic [DOM_W-1:0] acc_domain_i,
    input  logic             acc_is_data_i,
    input  logic             acc_is_section_i,
    input  logic             perm_ok_i,
    input  logic             burst_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             dom_fault_o,
    output logic             perm_fault_o
);

    logic [DACR_W-1:0] dacr;
    logic [STAT_W-1:0] status;

    dchk_domain_ctl #(.NUM_DOM(NUM_DOM)) ctl_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (reg_wr_i && !reg_sel_i),
        .wdata_i      (reg_wdata_i[DACR_W-1:0]),
        .acc_valid_i  (acc_valid_i),
        .acc_dom_i    (acc_domain_i),
        .perm_ok_i    (perm_ok_i),
        .dom_fault_o  (dom_fault_o),
        .perm_fault_o (perm_fault_o),
        .dacr_o       (dacr)
    );

    dchk_fault_status #(.NUM_DOM(NUM_DOM)) fs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .acc_valid_i  (acc_valid_i),
        .acc_dom_i    (acc_domain_i),
        .is_data_i    (acc_is_data_i),
        .is_section_i (acc_is_section_i),
        .burst_i      (burst_i),
        .dom_fault_i  (dom_fault_o),
        .perm_fault_i (perm_fault_o),
        .wr_en_i      (reg_wr_i && reg_sel_i),
        .wdata_i      (reg_wdata_i[STAT_W-1:0]),
        .status_o     (status)
    );

    always_comb begin
        if (reg_sel_i) begin
            reg_rdata_o = REG_W'(status);
        end else begin
            reg_rdata_o = REG_W'(dacr);
        end
    end

    // R6: a control-word write is visible on the read port next cycle
    assert_dacr_readback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !reg_sel_i) |=>
            (reg_sel_i || reg_rdata_o == REG_W'($past(reg_wdata_i[DACR_W-1:0]))));

endmodule

// File: tb/domain_fault_unit_tb.sv
`timescale 1ns/1ps
module domain_fault_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_dom = '0;
    logic        is_data = 1'b0;
    logic        is_sect = 1'b0;
    logic        perm_ok = 1'b0;
    logic        burst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dom_fault, perm_fault;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_dacr = '0;
    logic [7:0]  m_stat = '0;
    bit          m_lock = 1'b0;

    always #10 clk = ~clk;

    domain_fault_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .acc_valid_i(acc_valid), .acc_domain_i(acc_dom),
        .acc_is_data_i(is_data), .acc_is_section_i(is_sect),
        .perm_ok_i(perm_ok), .burst_i(burst),
        .reg_wr_i(reg_wr), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .dom_fault_o(dom_fault), .perm_fault_o(perm_fault)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, compare against the model, advance the model
    task automatic cyc(input bit v, input int dom, input bit d, input bit pok,
                       input bit sec, input bit bu, input bit wr, input bit sel,
                       input logic [31:0] wd, input string tag);
        logic [1:0] code;
        bit edom, eperm, rec;
        logic [31:0] erd;
        logic [3:0] ft;
        acc_valid = v; acc_dom = dom[3:0]; is_data = d; perm_ok = pok;
        is_sect = sec; burst = bu; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        #2;
        code  = m_dacr[2*dom +: 2];
        edom  = v && (code == 2'b00 || code == 2'b10);
        eperm = v && code == 2'b01 && !pok;
        erd   = sel ? {24'h0, m_stat} : m_dacr;
        check(tag, "dom_fault", {31'h0, dom_fault}, {31'h0, edom});
        check(tag, "perm_fault", {31'h0, perm_fault}, {31'h0, eperm});
        check(tag, "rdata", reg_rdata, erd);
        rec = v && d && (edom || eperm) && !(m_lock && bu);
        ft  = edom ? (sec ? 4'b1001 : 4'b1011) : (sec ? 4'b1101 : 4'b1111);
        if (rec) m_stat = {dom[3:0], ft};
        else if (wr && sel) m_stat = wd[7:0];
        if (wr && !sel) m_dacr = wd;
        m_lock = bu && (m_lock || rec);
        @(negedge clk);
    endtask

    task automatic idle(input bit sel, input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, sel, 32'h0, tag);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset contents
        reg_sel = 1'b0; #1; check("R1", "dacr in reset", reg_rdata, 32'h0);
        reg_sel = 1'b1; #1; check("R1", "status in reset", reg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cyc(1, 5, 0, 1, 0, 0, 0, 0, 32'h0, "R1");
        cyc(1, 15, 0, 1, 1, 0, 0, 1, 32'h0, "R1");

        // R6: load control word; d0=00 d1=01 d2=10 d3=11 d15=11
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'hC000_00E4, "R6");
        idle(0, "R6");

        // instruction fetches on every code: outputs only, status held
        for (int p = 0; p < 2; p++) begin
            cyc(1, 0, 0, p[0], 1, 0, 0, 1, 32'h0, "R2");
            cyc(1, 2, 0, p[0], 1, 0, 0, 1, 32'h0, "R3");
            cyc(1, 1, 0, p[0], 0, 0, 0, 1, 32'h0, "R4");
            cyc(1, 3, 0, p[0], 0, 0, 0, 1, 32'h0, "R5");
        end
        idle(1, "R8");

        // R7: each fault type
        cyc(1, 0, 1, 1, 1, 0, 0, 1, 32'h0, "R7");
        idle(1, "R7");
        cyc(1, 2, 1, 1, 0, 0, 0, 1, 32'h0, "R7");
        idle(1, "R7");
        cyc(1, 1, 1, 0, 1, 0, 0, 1, 32'h0, "R7");
        idle(1, "R7");
        cyc(1, 1, 1, 0, 0, 0, 0, 1, 32'h0, "R7");
        idle(1, "R7");
        cyc(1, 15, 1, 0, 0, 0, 0, 1, 32'h0, "R5");
        cyc(1, 0, 0, 1, 1, 0, 0, 1, 32'h0, "R8");
        idle(1, "R8");

        // R9: burst keeps first fault, clears after a gap
        cyc(1, 3, 1, 1, 0, 1, 0, 1, 32'h0, "R9");
        cyc(1, 1, 1, 0, 1, 1, 0, 1, 32'h0, "R9");
        cyc(1, 0, 1, 1, 0, 1, 0, 1, 32'h0, "R9");
        cyc(1, 2, 1, 1, 1, 1, 0, 1, 32'h0, "R9");
        idle(1, "R9");
        cyc(1, 2, 1, 1, 0, 1, 0, 1, 32'h0, "R9");
        cyc(1, 0, 1, 1, 1, 1, 0, 1, 32'h0, "R9");
        idle(1, "R9");

        // R10: software write to status
        cyc(0, 0, 0, 0, 0, 0, 1, 1, 32'hFFFF_FFA5, "R10");
        idle(1, "R10");
        cyc(1, 1, 0, 0, 0, 0, 1, 1, 32'h0000_0133, "R10");
        idle(1, "R10");

        // R11: fault capture beats simultaneous write
        cyc(1, 2, 1, 1, 1, 0, 1, 1, 32'h0000_0055, "R11");
        idle(1, "R11");

        // R12: idle inputs with fault-prone domain
        cyc(0, 0, 1, 0, 1, 0, 0, 1, 32'h0, "R12");
        cyc(0, 1, 1, 0, 0, 1, 0, 1, 32'h0, "R12");
        idle(1, "R12");

        // R6: all fields at their positions
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 32'h1B1B_6C93, "R6");
        for (int i = 0; i < 16; i++) begin
            cyc(1, i, 1, 0, i[0], 0, 0, 1, 32'h0, "R6");
        end
        idle(0, "R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule